// File: doc/BRIEF.md
# Two-Level Trigger Event Buffer

This block sits between a pixel front-end and its readout link and applies a two-stage trigger. Every clock cycle is one bunch crossing. Each readout chip on the shared bus may report one hit row per crossing: a valid bit, a row index and the column hit pattern of that row. The hits travel through a fixed-latency delay line sized to the first-level trigger latency. When a first-level strobe arrives, the crossing that happened exactly that many cycles earlier is frozen into a free slot of a small multi-event buffer, and it gets a sequential event number.

Stored events wait for a second-level decision, which always applies to the oldest event that has not yet had one. An accept queues the event for readout. A reject discards it without output. Accepted events leave in storage order as a framed word stream under a valid/ready handshake:

- a header that carries the event number;
- for each chip, from the lowest index to the highest, a chip-identifier word followed by one word per matrix row in row order;
- a trailer that repeats the event number.

When every slot is occupied the block raises busy. It then ignores further first-level strobes and counts them as dropped.

Top module: `trig_event_buffer`

## Requirements
- R1: While reset is held and just after it is released, out_valid_o is 0, busy_o is 0 and drop_cnt_o is 0.
- R2: A first-level strobe sampled at clock edge k stores the hit inputs sampled at edge k-L1_LAT (default 60). Hits from any other crossing are not stored.
- R3: An event opens with a header word (out_kind_o = 1) and closes with a trailer word (out_kind_o = 3). Both carry the event number in out_data_o[11:0], upper bits zero. Stored events are numbered 0, 1, 2, ... in storage order, modulo 4096.
- R4: Between header and trailer, each chip c from 0 to NCHIP-1 in turn gives a chip word (out_kind_o = 2, out_data_o = c) and then NROW row words (out_kind_o = 0) for rows 0 to NROW-1. A row word holds the stored pattern when that chip's stored hit is valid and names that row; otherwise it is zero. An event is exactly 2 + NCHIP*(NROW+1) words.
- R5: A stored event produces no output until a second-level accept has been applied to it.
- R6: A second-level reject frees the oldest undecided event and produces no output words for it.
- R7: busy_o is 1 exactly while NSLOT events are held. A first-level strobe while busy stores nothing, consumes no event number and increments drop_cnt_o by one.
- R8: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_kind_o and out_data_o hold their values.
- R9: Accepted events are read out in the order in which they were stored.
- R10: A second-level strobe that arrives when no stored event awaits a decision has no effect, and it is not remembered for a later event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle per bunch crossing |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_i | input | 1 | First-level trigger strobe |
| l2_acc_i | input | 1 | Second-level accept strobe |
| l2_rej_i | input | 1 | Second-level reject strobe |
| hit_vld_i | input | NCHIP | Per-chip hit-present flag for this crossing |
| hit_row_i | input | NCHIP*log2(NROW) | Per-chip hit row index, chip c at [c*RW +: RW] |
| hit_pat_i | input | NCHIP*NCOL | Per-chip column hit pattern, chip c at [c*NCOL +: NCOL] |
| out_ready_i | input | 1 | Downstream ready |
| out_valid_o | output | 1 | Output word valid |
| out_kind_o | output | 2 | Word kind: 0 row, 1 header, 2 chip, 3 trailer |
| out_data_o | output | NCOL | Word payload |
| busy_o | output | 1 | All buffer slots occupied |
| drop_cnt_o | output | 16 | Count of first-level strobes dropped while busy |

## Verification
The bench surrounds each real crossing with decoy crossings one cycle before and one cycle after. The decoys use the same rows with inverted patterns, so a delay line that is one stage short or long stores visibly wrong rows. Strobes are sent with nothing pending: a stray accept sent on an empty buffer and then replayed onto the next event would make that event appear without an L2. A rejected event is followed by an accepted one, which exposes any reject that emits words or fails to advance numbering. The buffer is filled to capacity and then sent one more strobe: a design that overwrites a slot, numbers the dropped event, or misses the drop count shows it in the event contents or the counter. Four queued events are then drained under a throttled ready, which catches words that change or vanish during a stall and events read out of order.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;

    typedef enum logic [1:0] {
        W_ROW  = 2'd0,
        W_HDR  = 2'd1,
        W_CHIP = 2'd2,
        W_TRL  = 2'd3
    } word_kind_e;

    typedef enum logic [1:0] {
        S_OPEN = 2'd0,
        S_ACC  = 2'd1,
        S_REJ  = 2'd2
    } slot_state_e;

    typedef enum logic [2:0] {
        P_IDLE = 3'd0,
        P_HDR  = 3'd1,
        P_CHIP = 3'd2,
        P_ROW  = 3'd3,
        P_TRL  = 3'd4
    } rd_phase_e;

endpackage

// File: rtl/evbuf_hit_delay.sv
module evbuf_hit_delay #(
    parameter int HW  = 370,
    parameter int LAT = 60
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] din_i,
    output logic [HW-1:0] dout_o
);

    generate
        if (LAT <= 1) begin : g_single
            typedef struct packed {
                logic [HW-1:0] stage;
            } one_t;

            one_t d, q;

            always_comb begin
                d       = q;
                d.stage = din_i;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end

            assign dout_o = q.stage;
        end else begin : g_chain
            typedef struct packed {
                logic [LAT-1:0][HW-1:0] stage;
            } pipe_t;

            pipe_t d, q;

            // stage[0] is the newest crossing, stage[LAT-1] the oldest
            always_comb begin
                d       = q;
                d.stage = {q.stage[LAT-2:0], din_i};
            end

            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end

            assign dout_o = q.stage[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/evbuf_slots.sv
module evbuf_slots
    import evbuf_pkg::*;
#(
    parameter int HW    = 370,
    parameter int NSLOT = 4,
    parameter int EVW   = 12,
    parameter int DROPW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l1_i,
    input  logic             l2_acc_i,
    input  logic             l2_rej_i,
    input  logic [HW-1:0]    hit_i,
    input  logic             pop_i,
    output logic             busy_o,
    output logic [DROPW-1:0] drop_cnt_o,
    output logic             head_acc_o,
    output logic [HW-1:0]    head_hit_o,
    output logic [EVW-1:0]   head_evt_o
);

    localparam int PW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int CW = $clog2(NSLOT + 1);

    typedef struct packed {
        logic [NSLOT-1:0][HW-1:0]  hit;
        logic [NSLOT-1:0][EVW-1:0] evt;
        logic [NSLOT-1:0][1:0]     st;
        logic [PW-1:0]             wr;
        logic [PW-1:0]             rd;
        logic [PW-1:0]             dp;
        logic [CW-1:0]             cnt;
        logic [CW-1:0]             open;
        logic [EVW-1:0]            nxt_evt;
        logic [DROPW-1:0]          drops;
    } slots_t;

    slots_t d, q;
    logic   full, store, pop, pop_rej, decide;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(NSLOT - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d       = q;
        full    = (q.cnt == CW'(NSLOT));
        store   = l1_i && !full;
        pop_rej = (q.cnt != '0) && (q.st[q.rd] == S_REJ);
        pop     = pop_rej || pop_i;
        decide  = (l2_acc_i || l2_rej_i) && (q.open != '0);

        if (store) begin
            d.hit[q.wr] = hit_i;
            d.evt[q.wr] = q.nxt_evt;
            d.st[q.wr]  = S_OPEN;
            d.wr        = ptr_next(q.wr);
            d.nxt_evt   = q.nxt_evt + EVW'(1);
        end
        // accept wins when both strobes coincide
        if (decide) begin
            d.st[q.dp] = l2_acc_i ? S_ACC : S_REJ;
            d.dp       = ptr_next(q.dp);
        end
        if (pop) begin
            d.rd = ptr_next(q.rd);
        end
        if (l1_i && full) begin
            d.drops = q.drops + DROPW'(1);
        end
        d.cnt  = q.cnt + CW'(store) - CW'(pop);
        d.open = q.open + CW'(store) - CW'(decide);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o     = full;
    assign drop_cnt_o = q.drops;
    assign head_acc_o = (q.cnt != '0) && (q.st[q.rd] == S_ACC);
    assign head_hit_o = q.hit[q.rd];
    assign head_evt_o = q.evt[q.rd];

    // R7: occupancy never exceeds the slot count
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(NSLOT));

    // R7: a strobe while busy bumps the drop counter
    a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && l1_i) |=> (drop_cnt_o == $past(drop_cnt_o) + DROPW'(1)));

    // R10: undecided events are a subset of held events
    a_r10_open_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.open <= q.cnt);

    // R6: a rejected head is released on the next edge
    a_r6_reject_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt != '0 && q.st[q.rd] == S_REJ && !l1_i) |=> (q.cnt == $past(q.cnt) - CW'(1)));

endmodule

// File: rtl/evbuf_reader.sv
module evbuf_reader
    import evbuf_pkg::*;
#(
    parameter int NCHIP = 10,
    parameter int NROW  = 16,
    parameter int NCOL  = 32,
    parameter int EVW   = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               head_acc_i,
    input  logic [NCHIP*(1+$clog2(NROW)+NCOL)-1:0] head_hit_i,
    input  logic [EVW-1:0]                     head_evt_i,
    input  logic                               out_ready_i,
    output logic                               out_valid_o,
    output logic [1:0]                         out_kind_o,
    output logic [NCOL-1:0]                    out_data_o,
    output logic                               pop_o
);

    localparam int RW  = $clog2(NROW);
    localparam int CHW = 1 + RW + NCOL;
    localparam int CIW = (NCHIP > 1) ? $clog2(NCHIP) : 1;

    typedef struct packed {
        rd_phase_e      ph;
        logic [CIW-1:0] chip;
        logic [RW-1:0]  row;
    } rd_t;

    rd_t             d, q;
    logic            fire;
    logic [CHW-1:0]  ch;
    logic            valid_c;
    logic [1:0]      kind_c;
    logic [NCOL-1:0] data_c;
    logic            pop_c;

    always_comb begin
        d       = q;
        pop_c   = 1'b0;
        valid_c = (q.ph != P_IDLE);
        fire    = valid_c && out_ready_i;
        ch      = head_hit_i[int'(q.chip)*CHW +: CHW];
        kind_c  = W_ROW;
        data_c  = '0;

        case (q.ph)
            P_HDR: begin
                kind_c            = W_HDR;
                data_c[EVW-1:0]   = head_evt_i;
            end
            P_CHIP: begin
                kind_c            = W_CHIP;
                data_c[CIW-1:0]   = q.chip;
            end
            P_ROW: begin
                kind_c = W_ROW;
                if (ch[CHW-1] && (ch[NCOL +: RW] == q.row)) data_c = ch[NCOL-1:0];
            end
            P_TRL: begin
                kind_c            = W_TRL;
                data_c[EVW-1:0]   = head_evt_i;
            end
            default: ;
        endcase

        case (q.ph)
            P_IDLE: begin
                if (head_acc_i) begin
                    d.ph   = P_HDR;
                    d.chip = '0;
                    d.row  = '0;
                end
            end
            P_HDR: begin
                if (fire) d.ph = P_CHIP;
            end
            P_CHIP: begin
                if (fire) begin
                    d.ph  = P_ROW;
                    d.row = '0;
                end
            end
            P_ROW: begin
                if (fire) begin
                    if (q.row == RW'(NROW - 1)) begin
                        if (q.chip == CIW'(NCHIP - 1)) begin
                            d.ph = P_TRL;
                        end else begin
                            d.chip = q.chip + CIW'(1);
                            d.ph   = P_CHIP;
                        end
                    end else begin
                        d.row = q.row + RW'(1);
                    end
                end
            end
            P_TRL: begin
                if (fire) begin
                    d.ph  = P_IDLE;
                    pop_c = 1'b1;
                end
            end
            default: d.ph = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid_o = valid_c;
    assign out_kind_o  = kind_c;
    assign out_data_o  = data_c;
    assign pop_o       = pop_c;

    // R8: a stalled word is held unchanged
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_kind_o) && $stable(out_data_o)));

    // R3: every event starts with a header
    a_r3_header_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> (out_kind_o == W_HDR));

    // R4: the header is followed by the word for chip 0
    a_r4_chip0_after_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && out_ready_i && out_kind_o == W_HDR) |=>
            (out_kind_o == W_CHIP && out_data_o == '0));

    // R5: output only appears for an accepted head
    a_r5_start_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid_o) |-> $past(head_acc_i));

endmodule

// File: rtl/trig_event_buffer.sv
module trig_event_buffer #(
    parameter int NCHIP  = 10,
    parameter int NROW   = 16,
    parameter int NCOL   = 32,
    parameter int NSLOT  = 4,
    parameter int L1_LAT = 60,
    parameter int EVW    = 12,
    parameter int DROPW  = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           l1_i,
    input  logic                           l2_acc_i,
    input  logic                           l2_rej_i,
    input  logic [NCHIP-1:0]               hit_vld_i,
    input  logic [NCHIP*$clog2(NROW)-1:0]  hit_row_i,
    input  logic [NCHIP*NCOL-1:0]          hit_pat_i,
    input  logic                           out_ready_i,
    output logic                           out_valid_o,
    output logic [1:0]                     out_kind_o,
    output logic [NCOL-1:0]                out_data_o,
    output logic                           busy_o,
    output logic [DROPW-1:0]               drop_cnt_o
);

    localparam int RW  = $clog2(NROW);
    localparam int CHW = 1 + RW + NCOL;
    localparam int HW  = NCHIP * CHW;

    logic [HW-1:0]  hit_now;
    logic [HW-1:0]  hit_late;
    logic [HW-1:0]  head_hit;
    logic [EVW-1:0] head_evt;
    logic           head_acc;
    logic           pop;

    // per-chip record: {valid, row, pattern}
    generate
        for (genvar c = 0; c < NCHIP; c++) begin : g_pack
            assign hit_now[c*CHW +: CHW] =
                {hit_vld_i[c], hit_row_i[c*RW +: RW], hit_pat_i[c*NCOL +: NCOL]};
        end
    endgenerate

    evbuf_hit_delay #(
        .HW  (HW),
        .LAT (L1_LAT)
    ) u_delay (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (hit_now),
        .dout_o (hit_late)
    );

    evbuf_slots #(
        .HW    (HW),
        .NSLOT (NSLOT),
        .EVW   (EVW),
        .DROPW (DROPW)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .l1_i       (l1_i),
        .l2_acc_i   (l2_acc_i),
        .l2_rej_i   (l2_rej_i),
        .hit_i      (hit_late),
        .pop_i      (pop),
        .busy_o     (busy_o),
        .drop_cnt_o (drop_cnt_o),
        .head_acc_o (head_acc),
        .head_hit_o (head_hit),
        .head_evt_o (head_evt)
    );

    evbuf_reader #(
        .NCHIP (NCHIP),
        .NROW  (NROW),
        .NCOL  (NCOL),
        .EVW   (EVW)
    ) u_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_acc_i  (head_acc),
        .head_hit_i  (head_hit),
        .head_evt_i  (head_evt),
        .out_ready_i (out_ready_i),
        .out_valid_o (out_valid_o),
        .out_kind_o  (out_kind_o),
        .out_data_o  (out_data_o),
        .pop_o       (pop)
    );

    // R1: nothing is presented in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid_o && !busy_o));

endmodule

// File: tb/trig_event_buffer_tb.sv
module trig_event_buffer_tb;
    import evbuf_pkg::*;

    localparam int NCHIP = 10;
    localparam int NROW  = 16;
    localparam int NCOL  = 32;
    localparam int NSLOT = 4;
    localparam int LAT   = 60;
    localparam int EVW   = 12;
    localparam int DROPW = 16;
    localparam int RW    = $clog2(NROW);
    localparam int EW    = 2 + NCHIP * (NROW + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                  rst_n = 1'b0;
    logic                  l1 = 1'b0, l2a = 1'b0, l2r = 1'b0;
    logic [NCHIP-1:0]      hv = '0;
    logic [NCHIP*RW-1:0]   hr = '0;
    logic [NCHIP*NCOL-1:0] hp = '0;
    logic                  rdy = 1'b1;
    logic                  out_valid;
    logic [1:0]            out_kind;
    logic [NCOL-1:0]       out_data;
    logic                  busy;
    logic [DROPW-1:0]      drops;

    trig_event_buffer #(
        .NCHIP (NCHIP), .NROW (NROW), .NCOL (NCOL), .NSLOT (NSLOT),
        .L1_LAT (LAT), .EVW (EVW), .DROPW (DROPW)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .l1_i (l1), .l2_acc_i (l2a), .l2_rej_i (l2r),
        .hit_vld_i (hv), .hit_row_i (hr), .hit_pat_i (hp), .out_ready_i (rdy),
        .out_valid_o (out_valid), .out_kind_o (out_kind), .out_data_o (out_data),
        .busy_o (busy), .drop_cnt_o (drops)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // capture of every accepted word, and stall stability check
    logic [1:0]      cap_k [0:4095];
    logic [NCOL-1:0] cap_d [0:4095];
    int              cap_n = 0;
    bit              prv_stall = 1'b0;
    logic [1:0]      prv_k;
    logic [NCOL-1:0] prv_d;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prv_stall)
                chk(out_valid && out_kind == prv_k && out_data == prv_d, "R8",
                    "word held during stall", {out_kind, out_data}, {prv_k, prv_d});
            prv_stall = out_valid && !rdy;
            prv_k     = out_kind;
            prv_d     = out_data;
            if (out_valid && rdy && cap_n < 4096) begin
                cap_k[cap_n] = out_kind;
                cap_d[cap_n] = out_data;
                cap_n++;
            end
        end
    end

    // ready driver: throttled pattern when stall_mode is set
    bit stall_mode = 1'b0;
    int cyc = 0;
    always @(posedge clk) begin
        #1;
        cyc++;
        rdy = stall_mode ? ((cyc % 7) < 4) : 1'b1;
    end

    // expected hit content per event index
    bit              ev_v [0:15][0:NCHIP-1];
    int              ev_r [0:15][0:NCHIP-1];
    logic [NCOL-1:0] ev_p [0:15][0:NCHIP-1];

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic make_event(input int idx);
        for (int c = 0; c < NCHIP; c++) begin
            ev_v[idx][c] = ((c + idx) % 3) != 2;
            ev_r[idx][c] = (c * 5 + idx * 3) % NROW;
            ev_p[idx][c] = NCOL'(32'h9E3779B9 * (idx * 16 + c + 1));
        end
    endtask

    task automatic set_hits(input int idx, input bit decoy);
        for (int c = 0; c < NCHIP; c++) begin
            hv[c]               = decoy ? 1'b1 : ev_v[idx][c];
            hr[c*RW +: RW]      = RW'(ev_r[idx][c]);
            hp[c*NCOL +: NCOL]  = decoy ? ~ev_p[idx][c] : ev_p[idx][c];
        end
    endtask

    // decoy crossing, real crossing (edge k), decoy, then L1 at edge k+LAT
    task automatic store_event(input int idx);
        set_hits(idx, 1'b1); step();
        set_hits(idx, 1'b0); step();
        set_hits(idx, 1'b1); step();
        hv = '0; hr = '0; hp = '0;
        repeat (LAT - 2) step();
        l1 = 1'b1; step(); l1 = 1'b0;
    endtask

    task automatic pulse_acc();
        l2a = 1'b1; step(); l2a = 1'b0;
    endtask

    task automatic pulse_rej();
        l2r = 1'b1; step(); l2r = 1'b0;
    endtask

    task automatic wait_words(input int n, input string req);
        int t = 0;
        while (cap_n < n && t < 8000) begin
            step();
            t++;
        end
        repeat (10) step();
        chk(cap_n == n, req, "word count", cap_n, n);
    endtask

    task automatic check_event(input int base, input int idx, input int evt, input string req);
        int w = base;
        logic [NCOL-1:0] e;
        chk(cap_k[w] == W_HDR && cap_d[w] == NCOL'(evt % 4096), req, "header",
            {cap_k[w], cap_d[w]}, {W_HDR, NCOL'(evt % 4096)});
        w++;
        for (int c = 0; c < NCHIP; c++) begin
            chk(cap_k[w] == W_CHIP && cap_d[w] == NCOL'(c), "R4", "chip word",
                {cap_k[w], cap_d[w]}, {W_CHIP, NCOL'(c)});
            w++;
            for (int r = 0; r < NROW; r++) begin
                e = (ev_v[idx][c] && ev_r[idx][c] == r) ? ev_p[idx][c] : '0;
                chk(cap_k[w] == W_ROW && cap_d[w] == e, "R2 R4", "row word",
                    {cap_k[w], cap_d[w]}, {W_ROW, e});
                w++;
            end
        end
        chk(cap_k[w] == W_TRL && cap_d[w] == NCOL'(evt % 4096), "R3", "trailer",
            {cap_k[w], cap_d[w]}, {W_TRL, NCOL'(evt % 4096)});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) step();
        chk(!out_valid && !busy && drops == '0, "R1", "state in reset",
            {out_valid, busy, drops}, 0);
        rst_n = 1'b1;
        step();
        chk(!out_valid && !busy && drops == '0, "R1", "state after reset",
            {out_valid, busy, drops}, 0);
    endtask

    task automatic t_single();
        make_event(0);
        store_event(0);
        repeat (20) step();
        chk(cap_n == 0 && !out_valid, "R5", "no output before accept", cap_n, 0);
        pulse_acc();
        wait_words(EW, "R4");
        check_event(0, 0, 0, "R3");
    endtask

    task automatic t_reject();
        int base = cap_n;
        make_event(1);
        store_event(1);
        pulse_rej();
        repeat (30) step();
        chk(cap_n == base && !out_valid, "R6", "reject emits nothing", cap_n, base);
        make_event(2);
        store_event(2);
        pulse_acc();
        wait_words(base + EW, "R6");
        check_event(base, 2, 2, "R6");
    endtask

    task automatic t_empty_l2();
        int base = cap_n;
        pulse_acc();
        repeat (10) step();
        chk(cap_n == base && !out_valid, "R10", "accept on empty ignored", cap_n, base);
        make_event(3);
        store_event(3);
        repeat (30) step();
        chk(cap_n == base && !out_valid, "R10", "stray accept not retained", cap_n, base);
        pulse_acc();
        wait_words(base + EW, "R10");
        check_event(base, 3, 3, "R10");
    endtask

    task automatic t_full_stall();
        int base = cap_n;
        for (int k = 0; k < NSLOT; k++) begin
            make_event(4 + k);
            store_event(4 + k);
            chk(busy == (k == NSLOT - 1), "R7", "busy while filling", busy, (k == NSLOT - 1));
        end
        make_event(8);
        store_event(8);
        chk(drops == DROPW'(1), "R7", "drop counted", drops, 1);
        chk(busy, "R7", "still busy", busy, 1);
        stall_mode = 1'b1;
        for (int k = 0; k < NSLOT; k++) pulse_acc();
        wait_words(base + NSLOT * EW, "R9");
        for (int k = 0; k < NSLOT; k++) check_event(base + k * EW, 4 + k, 4 + k, "R9");
        stall_mode = 1'b0;
        step();
        chk(!busy, "R7", "busy clears after drain", busy, 0);
        base = cap_n;
        make_event(9);
        store_event(9);
        pulse_acc();
        wait_words(base + EW, "R7");
        check_event(base, 9, 8, "R7");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single();
        t_reject();
        t_empty_l2();
        t_full_stall();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule